// File: doc/BRIEF.md
# Mesh Node Message Switch

This block is the message switch that sits inside every node of a two-dimensional processing mesh. It has five ports, each made of a receive side and a transmit side: one towards each of the four adjacent nodes (north, south, east, west) and one towards the node's own logic (local). Every port moves single-beat 32-bit messages under a valid/ready handshake. Each switch links only to its immediate neighbours, yet a message reaches any node of the mesh by hopping from switch to switch. The same fabric carries configuration loads, signal values exchanged between nodes, and output samples travelling down to the collector below each column.

Each message names a destination row and column. The switch first corrects the column, east or west, and then the row, south or north. A message whose row and column both equal the node's own position leaves through the local port. Output-kind messages, once in the right column, always head south towards the column collector. Nodes on an edge or in a corner lack up to two neighbour ports. A port-enable parameter marks the missing ones, and the switch keeps working without them. When several receive sides want the same transmit side, a round-robin arbiter per transmit side picks one. The winner keeps that transmit side until its message is taken.

Each transmit side is run by a two-state machine. `ARB_IDLE` means no message is offered. Its transition `grant` goes to `ARB_BUSY` when at least one receive side requests the port, and it latches the round-robin winner. `ARB_BUSY` offers the winner's message. Its transition `stall` stays in `ARB_BUSY` while ready is low. Its transition `release` goes back to `ARB_IDLE` when ready is high; it completes the handshake on both sides and moves the round-robin pointer to the next position after the winner.

Top module: `mesh_router`

## Requirements
- R1: After reset, every transmit valid and every receive ready is low until a message is offered.
- R2: A config-kind (code 00) or signal-kind (code 01) message whose row (bits 31:28) and column (bits 27:24) equal the node's position leaves on the local port.
- R3: A message whose column differs from the node's goes east if its column is larger and west if smaller, whatever its row.
- R4: A message in the node's column goes south if its row is larger and north if smaller. Rows grow towards the south.
- R5: An output-kind message (code 10, kind field in bits 23:22) in the node's column goes south whatever its row.
- R6: An offered message keeps its transmit valid high and its data unchanged until transmit ready is seen. The source's receive ready is high only in that cycle. The message leaves bit-for-bit unchanged and is never dropped.
- R7: Competing receive sides are served in round-robin order north, south, east, west, local, starting after the previous winner. A source that asks again right after winning waits behind the others.
- R8: On an absent port the receive side is ignored (ready stays low and no transmit side is driven), and the transmit side never raises valid. A message whose next hop would use an absent port is delivered on the local port instead.
- R9: A message offered to an idle transmit side appears there one clock later. Transmit sides not in contention work at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 5 | Receive valid per port (index 0 N, 1 S, 2 E, 3 W, 4 local) |
| rx_data | input | 5x32 | Receive message per port |
| rx_ready | output | 5 | Receive ready per port |
| tx_valid | output | 5 | Transmit valid per port |
| tx_data | output | 5x32 | Transmit message per port |
| tx_ready | input | 5 | Transmit ready per port |

## Verification
The bench uses a node in the middle of the mesh with its north port disabled. It aims at the column-before-row order: a switch that corrected the row first would send a message for another column south and not west. It also checks that output-kind messages skip local delivery, and that a message needing the missing north link falls back to the local port and is not lost. It stalls a transmit side to show that valid and data hold and that the source is not released early. It drives a dead receive side to show that nothing moves. Finally it puts four sources on the local port, with the first winner asking again at once, so that a fixed-priority arbiter, which would serve that source twice in a row, is caught.

// File: rtl/rtr_pkg.sv
package rtr_pkg;
    localparam int ROW_W  = 4;
    localparam int COL_W  = 4;
    localparam int KIND_W = 2;
    localparam int BODY_W = 22;
    localparam int MSG_W  = ROW_W + COL_W + KIND_W + BODY_W;
    localparam int NPORT  = 5;

    localparam int P_N = 0;
    localparam int P_S = 1;
    localparam int P_E = 2;
    localparam int P_W = 3;
    localparam int P_L = 4;

    typedef enum logic [KIND_W-1:0] {
        K_CFG = 2'b00,
        K_SIG = 2'b01,
        K_OUT = 2'b10,
        K_RSV = 2'b11
    } kind_e;

    typedef struct packed {
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [KIND_W-1:0] kind;
        logic [BODY_W-1:0] body;
    } msg_t;
endpackage

// File: rtl/rtr_route.sv
module rtr_route
    import rtr_pkg::*;
#(
    parameter int               MY_ROW  = 0,
    parameter int               MY_COL  = 0,
    parameter logic [NPORT-1:0] PORT_EN = '1
) (
    input  logic [ROW_W-1:0]  dst_row,
    input  logic [COL_W-1:0]  dst_col,
    input  logic [KIND_W-1:0] kind,
    output logic [NPORT-1:0]  dest
);
    localparam logic [ROW_W-1:0] HERE_ROW = ROW_W'(MY_ROW);
    localparam logic [COL_W-1:0] HERE_COL = COL_W'(MY_COL);

    int hop;

    always_comb begin
        // column first (R3), then row (R4); output kind heads south (R5)
        if (dst_col > HERE_COL)
            hop = P_E;
        else if (dst_col < HERE_COL)
            hop = P_W;
        else if (kind == K_OUT)
            hop = P_S;
        else if (dst_row > HERE_ROW)
            hop = P_S;
        else if (dst_row < HERE_ROW)
            hop = P_N;
        else
            hop = P_L;
        // absent next hop falls back to local delivery (R8)
        if (!PORT_EN[hop])
            hop = P_L;
        dest = '0;
        dest[hop] = 1'b1;
    end
endmodule

// File: rtl/rtr_arbiter.sv
module rtr_arbiter #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         out_ready,
    output logic         out_valid,
    output logic [N-1:0] grant,
    output logic         accept
);
    localparam int PW = (N > 1) ? $clog2(N) : 1;

    typedef enum logic {
        ARB_IDLE = 1'b0,
        ARB_BUSY = 1'b1
    } arb_state_e;

    arb_state_e    state_q, state_d;
    logic [PW-1:0] ptr_q, ptr_d;
    logic [PW-1:0] win_q, win_d;
    logic [PW-1:0] pick;
    logic          pick_hit;

    // round-robin search starting at the pointer
    always_comb begin
        pick     = '0;
        pick_hit = 1'b0;
        for (int k = 0; k < N; k++) begin
            int j;
            j = int'(ptr_q) + k;
            if (j >= N)
                j = j - N;
            if (!pick_hit && req[j]) begin
                pick     = PW'(j);
                pick_hit = 1'b1;
            end
        end
    end

    always_comb begin
        state_d = state_q;
        win_d   = win_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ARB_IDLE: begin
                if (pick_hit) begin
                    state_d = ARB_BUSY;
                    win_d   = pick;
                end
            end
            ARB_BUSY: begin
                if (out_ready) begin
                    state_d = ARB_IDLE;
                    ptr_d   = (int'(win_q) == N - 1) ? '0 : win_q + 1'b1;
                end
            end
            default: state_d = ARB_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            ptr_q   <= '0;
            win_q   <= '0;
        end else begin
            state_q <= state_d;
            ptr_q   <= ptr_d;
            win_q   <= win_d;
        end
    end

    always_comb begin
        out_valid = 1'b0;
        grant     = '0;
        unique case (state_q)
            ARB_IDLE: ;
            ARB_BUSY: begin
                out_valid    = 1'b1;
                grant[win_q] = 1'b1;
            end
            default: ;
        endcase
        accept = out_valid & out_ready;
    end

    a_r6_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=> (out_valid && $stable(grant)));

    a_r7_grant_live: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> ((grant & req) != '0));
endmodule

// File: rtl/mesh_router.sv
module mesh_router
    import rtr_pkg::*;
#(
    parameter int               NODE_ROW = 2,
    parameter int               NODE_COL = 3,
    parameter logic [NPORT-1:0] PORT_EN  = 5'b11111
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic [NPORT-1:0]            rx_valid,
    input  logic [NPORT-1:0][MSG_W-1:0] rx_data,
    output logic [NPORT-1:0]            rx_ready,
    output logic [NPORT-1:0]            tx_valid,
    output logic [NPORT-1:0][MSG_W-1:0] tx_data,
    input  logic [NPORT-1:0]            tx_ready
);
    localparam logic [NPORT-1:0] EN = PORT_EN | (NPORT'(1) << P_L);

    logic [NPORT-1:0]            rx_live;
    logic [NPORT-1:0][NPORT-1:0] dest_m;   // [src][dst]
    logic [NPORT-1:0][NPORT-1:0] req_m;    // [dst][src]
    logic [NPORT-1:0][NPORT-1:0] grant_m;  // [dst][src]
    logic [NPORT-1:0]            acc_o;

    for (genvar i = 0; i < NPORT; i++) begin : g_rx
        msg_t m;
        assign m          = msg_t'(rx_data[i]);
        assign rx_live[i] = rx_valid[i] & EN[i];
        rtr_route #(
            .MY_ROW (NODE_ROW),
            .MY_COL (NODE_COL),
            .PORT_EN(EN)
        ) u_route (
            .dst_row(m.row),
            .dst_col(m.col),
            .kind   (m.kind),
            .dest   (dest_m[i])
        );
    end

    always_comb begin
        for (int o = 0; o < NPORT; o++)
            for (int i = 0; i < NPORT; i++)
                req_m[o][i] = rx_live[i] & dest_m[i][o];
    end

    for (genvar o = 0; o < NPORT; o++) begin : g_tx
        if (EN[o]) begin : g_on
            rtr_arbiter #(.N(NPORT)) u_arb (
                .clk      (clk),
                .rst_n    (rst_n),
                .req      (req_m[o]),
                .out_ready(tx_ready[o]),
                .out_valid(tx_valid[o]),
                .grant    (grant_m[o]),
                .accept   (acc_o[o])
            );
            always_comb begin
                tx_data[o] = '0;
                for (int i = 0; i < NPORT; i++)
                    if (grant_m[o][i])
                        tx_data[o] = rx_data[i];
            end
            a_r6_data_hold: assert property (@(posedge clk) disable iff (!rst_n)
                (tx_valid[o] && !tx_ready[o]) |=> $stable(tx_data[o]));
        end else begin : g_off
            assign tx_valid[o] = 1'b0;
            assign grant_m[o]  = '0;
            assign acc_o[o]    = 1'b0;
            assign tx_data[o]  = '0;
        end
    end

    logic [NPORT-1:0][NPORT-1:0] take_m;  // [src][dst]

    always_comb begin
        for (int i = 0; i < NPORT; i++) begin
            for (int o = 0; o < NPORT; o++)
                take_m[i][o] = grant_m[o][i] & acc_o[o];
            rx_ready[i] = |take_m[i];
        end
    end

    for (genvar i = 0; i < NPORT; i++) begin : g_chk
        a_r6_ready_needs_valid: assert property (@(posedge clk) disable iff (!rst_n)
            rx_ready[i] |-> rx_valid[i]);
        a_r6_single_take: assert property (@(posedge clk) disable iff (!rst_n)
            $onehot0(take_m[i]));
    end
endmodule

// File: tb/test_mesh_router.sv
module test_mesh_router;
    import rtr_pkg::*;

    logic                        clk = 1'b0;
    logic                        rst_n = 1'b0;
    logic [NPORT-1:0]            rx_valid = '0;
    logic [NPORT-1:0][MSG_W-1:0] rx_data = '0;
    logic [NPORT-1:0]            rx_ready;
    logic [NPORT-1:0]            tx_valid;
    logic [NPORT-1:0][MSG_W-1:0] tx_data;
    logic [NPORT-1:0]            tx_ready = '1;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    always #4 clk = ~clk;

    mesh_router #(.NODE_ROW(2), .NODE_COL(3), .PORT_EN(5'b11110)) i_mesh_router (
        .clk(clk), .rst_n(rst_n),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready)
    );

    function automatic logic [31:0] mk(int row, int col, int kind, int body);
        return {4'(row), 4'(col), 2'(kind), 22'(body)};
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic do_reset();
        rx_valid = '0;
        tx_ready = '1;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // offer one message and expect it on one transmit side a clock later
    task automatic route_one(input int src, input logic [31:0] m, input int dst, input string tag);
        @(negedge clk);
        rx_data[src]  = m;
        rx_valid[src] = 1'b1;
        @(negedge clk);
        chk(tx_valid == 5'(1 << dst), {tag, " valid"}, 32'(tx_valid), 32'(1 << dst));
        chk(tx_data[dst] == m, {tag, " data"}, tx_data[dst], m);
        chk(rx_ready == 5'(1 << src), {tag, " ready"}, 32'(rx_ready), 32'(1 << src));
        @(negedge clk);
        rx_valid[src] = 1'b0;
        chk(tx_valid == '0, {tag, " idle after"}, 32'(tx_valid), 0);
    endtask

    task automatic t_reset();
        do_reset();
        @(negedge clk);
        chk(tx_valid == '0, "R1 tx_valid after reset", 32'(tx_valid), 0);
        chk(rx_ready == '0, "R1 rx_ready after reset", 32'(rx_ready), 0);
    endtask

    task automatic t_routes();
        route_one(P_L, mk(2, 3, K_SIG, 'h111), P_L, "R2 signal local");
        route_one(P_S, mk(2, 3, K_CFG, 'h222), P_L, "R2 config local");
        route_one(P_L, mk(2, 5, K_SIG, 'h333), P_E, "R3 east");
        route_one(P_E, mk(7, 1, K_SIG, 'h444), P_W, "R3 west before row");
        route_one(P_W, mk(0, 9, K_CFG, 'h555), P_E, "R3 east before north");
        route_one(P_L, mk(6, 3, K_SIG, 'h666), P_S, "R4 south");
        route_one(P_L, mk(2, 3, K_OUT, 'h777), P_S, "R5 output skips local");
        route_one(P_W, mk(0, 3, K_OUT, 'h888), P_S, "R5 output any row");
        route_one(P_S, mk(0, 3, K_SIG, 'h999), P_L, "R8 north absent falls back");
    endtask

    task automatic t_stall();
        logic [31:0] m;
        m = mk(5, 3, K_SIG, 'h0abc);
        @(negedge clk);
        tx_ready[P_S] = 1'b0;
        rx_data[P_W]  = m;
        rx_valid[P_W] = 1'b1;
        for (int c = 0; c < 4; c++) begin
            @(negedge clk);
            chk(tx_valid[P_S] == 1'b1, "R6 valid held in stall", 32'(tx_valid), 32'(1 << P_S));
            chk(tx_data[P_S] == m, "R6 data held in stall", tx_data[P_S], m);
            chk(rx_ready[P_W] == 1'b0, "R6 no early release", 32'(rx_ready), 0);
        end
        tx_ready[P_S] = 1'b1;
        #1;
        chk(rx_ready[P_W] == 1'b1, "R6 release on ready", 32'(rx_ready), 32'(1 << P_W));
        @(negedge clk);
        rx_valid[P_W] = 1'b0;
        chk(tx_valid == '0, "R6 idle after release", 32'(tx_valid), 0);
    endtask

    task automatic t_dead_input();
        @(negedge clk);
        rx_data[P_N]  = mk(2, 3, K_SIG, 'h0dea);
        rx_valid[P_N] = 1'b1;
        for (int c = 0; c < 3; c++) begin
            @(negedge clk);
            chk(tx_valid == '0, "R8 absent input drives nothing", 32'(tx_valid), 0);
            chk(rx_ready == '0, "R8 absent input not ready", 32'(rx_ready), 0);
        end
        rx_valid[P_N] = 1'b0;
    endtask

    task automatic t_parallel();
        logic [31:0] a, b;
        a = mk(9, 3, K_SIG, 'h0a0a);
        b = mk(2, 0, K_CFG, 'h0b0b);
        @(negedge clk);
        rx_data[P_L] = a; rx_valid[P_L] = 1'b1;
        rx_data[P_S] = b; rx_valid[P_S] = 1'b1;
        @(negedge clk);
        chk(tx_valid == 5'((1 << P_S) | (1 << P_W)), "R9 two outputs at once", 32'(tx_valid), 32'((1 << P_S) | (1 << P_W)));
        chk(tx_data[P_S] == a, "R9 south data", tx_data[P_S], a);
        chk(tx_data[P_W] == b, "R9 west data", tx_data[P_W], b);
        chk(rx_ready == 5'((1 << P_L) | (1 << P_S)), "R9 both released", 32'(rx_ready), 32'((1 << P_L) | (1 << P_S)));
        @(negedge clk);
        rx_valid = '0;
    endtask

    task automatic t_fair();
        logic [31:0] m [NPORT];
        int order [5];
        logic [31:0] again;
        do_reset();
        for (int p = 0; p < NPORT; p++)
            m[p] = mk(2, 3, K_SIG, 'h100 + p);
        again = mk(2, 3, K_CFG, 'h1ff);
        order = '{P_S, P_E, P_W, P_L, P_S};
        @(negedge clk);
        for (int p = 1; p < NPORT; p++) begin
            rx_data[p]  = m[p];
            rx_valid[p] = 1'b1;
        end
        for (int k = 0; k < 5; k++) begin
            logic [31:0] exp;
            exp = (k == 4) ? again : m[order[k]];
            @(negedge clk);
            chk(tx_valid[P_L] == 1'b1, "R7 local busy", 32'(tx_valid), 32'(1 << P_L));
            chk(tx_data[P_L] == exp, "R7 round-robin winner", tx_data[P_L], exp);
            chk(rx_ready == 5'(1 << order[k]), "R7 winner released", 32'(rx_ready), 32'(1 << order[k]));
            @(negedge clk);
            if (k == 0)
                rx_data[P_S] = again;
            else
                rx_valid[order[k]] = 1'b0;
        end
        chk(rx_valid == '0, "R7 all served", 32'(rx_valid), 0);
    endtask

    initial begin
        t_reset();
        t_routes();
        t_stall();
        t_dead_input();
        t_parallel();
        t_fair();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule